// File: doc/BRIEF.md
# Watchdog Timer with Keyed Feed Sequence

This block is a watchdog timer. Software must service it now and then with a two-write unlock sequence. When the servicing stops, a down counter runs out and the block asks the rest of the chip for a reset. The counting clock comes from one of two sources: the system clock, or a separate slow watchdog clock that is synchronized into the system domain. The count path is a fixed divide-by-32 stage, then a power-of-two prescaler, then an 8-bit down counter.

Software reaches the block through a plain write bus with an address, a data byte and a strobe. There are four registers: control, reload, first key and second key. A control write does not take effect at once. It sits in a staging copy until the next valid key sequence commits it, so a single stray store cannot disable or slow the watchdog. A wrong key value, keys in the wrong order, any other write between the two keys, or a control write not followed by a valid key sequence all give an immediate reset request.

Top module: `wdt_feed_guard`

## Requirements
- R1: Register addresses are: control 0, reload 1, first key 2, second key 3. A valid feed is a write of 0xA5 to address 2, then a write of 0x5A to address 3. Idle cycles between the two are allowed. A valid feed loads the down counter from the reload register, clears the divider chain and raises no reset.
- R2: Writing a value other than 0xA5 to address 2 gives a reset request. So does writing to address 3 when no correct first key is pending, or writing a value other than 0x5A as the second key.
- R3: After a correct first key, any write other than a correct second key aborts the sequence and gives a reset request. The block then waits for a new first key.
- R4: A control write goes to a staging copy and changes no behaviour until the next valid feed commits it. If the next write after a control write is not the start of a valid feed, or the feed is not completed, a reset is requested and the staged value is never committed.
- R5: Control layout: bit 0 enables counting, bit 2 selects the tick source (0 = system clock cycle, 1 = rising edge of the synchronized watchdog clock), bits 5:3 hold N. One counter step takes 32*2^N ticks. With bit 0 clear the counter holds.
- R6: After a feed with reload value R, the counter underflows on step R+1. On that step the timeout flag is set, a reset is requested and the counter reloads from R.
- R7: Control bit 1 is the timeout flag (output `timeout_o`). Only underflow sets it. It stays set until a committed control value has bit 1 at 0. Committing a 1 cannot set it.
- R8: A reset request is a registered pulse of RST_LEN (default 4) system cycles. It starts on the edge that registers the cause. A new cause restarts the full length.
- R9: After reset, `rst_req_o` and `timeout_o` are low, counting is disabled and the reload register holds 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wd_clk_i | input | 1 | Slow watchdog clock, sampled through a synchronizer |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rst_req_o | output | 1 | Reset request pulse |
| timeout_o | output | 1 | Timeout flag |

## Verification
The assertions check on every cycle that:
- each bad feed is followed by a reset request;
- an underflow sets the flag;
- the flag stays set unless a commit clears it;
- the active control fields change only on a valid feed;
- a feed loads the reload value;
- the counter holds while counting is disabled;
- a reset pulse lasts more than one cycle.

Only the bench scenarios can show the end-to-end behaviour:
- the exact underflow cycle for a given prescaler and reload;
- that a staged control write which was never committed leaves the timer idle;
- the timing of the watchdog-clock source;
- the restart of the pulse length when a new cause arrives.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int PRESC_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_KEY_A  = 2'd2,
    REG_KEY_B  = 2'd3
  } reg_addr_e;

  localparam logic [DATA_W-1:0] KEY_A_VAL = 8'hA5;
  localparam logic [DATA_W-1:0] KEY_B_VAL = 8'h5A;

  typedef struct packed {
    logic [1:0]         rsvd;
    logic [PRESC_W-1:0] presc;
    logic               clk_sel;
    logic               tof;
    logic               run;
  } ctrl_t;
endpackage

// File: rtl/wdt_feed_ctrl.sv
module wdt_feed_ctrl
  import wdt_pkg::*;
#(
  parameter logic [DATA_W-1:0] RELOAD_RST = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              underflow_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] reload_o,
  output logic              feed_ok_o,
  output logic              bad_feed_o
);
  logic  armed_q, pend_q;
  ctrl_t ctrl_q, shadow_q;
  logic [DATA_W-1:0] reload_q;
  logic  wr_ctrl, wr_rel, wr_a, wr_b, key_a_ok, key_b_ok, bad;

  always_comb begin
    wr_ctrl  = we_i && (addr_i == REG_CTRL);
    wr_rel   = we_i && (addr_i == REG_RELOAD);
    wr_a     = we_i && (addr_i == REG_KEY_A);
    wr_b     = we_i && (addr_i == REG_KEY_B);
    key_a_ok = wr_a && (wdata_i == KEY_A_VAL);
    key_b_ok = wr_b && (wdata_i == KEY_B_VAL) && armed_q;
    if (!we_i)        bad = 1'b0;
    else if (armed_q) bad = !key_b_ok;
    else if (pend_q)  bad = !key_a_ok;
    else              bad = (wr_a && !key_a_ok) || wr_b;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      pend_q   <= 1'b0;
      shadow_q <= '0;
      ctrl_q   <= '0;
      reload_q <= RELOAD_RST;
    end else begin
      if (we_i) armed_q <= !armed_q && key_a_ok;
      if (bad || key_b_ok) pend_q <= 1'b0;
      else if (wr_ctrl)    pend_q <= 1'b1;
      if (wr_ctrl) shadow_q <= ctrl_t'(wdata_i);
      if (wr_rel)  reload_q <= wdata_i;
      if (key_b_ok && pend_q) begin
        ctrl_q      <= shadow_q;
        ctrl_q.rsvd <= '0;
        ctrl_q.tof  <= ctrl_q.tof & shadow_q.tof;  // flag can only be cleared
      end else if (underflow_i) begin
        ctrl_q.tof  <= 1'b1;
      end
    end
  end

  assign ctrl_o     = ctrl_q;
  assign reload_o   = reload_q;
  assign feed_ok_o  = key_b_ok;
  assign bad_feed_o = bad;
endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int FIX_LOG2    = 5,
  parameter int PRE_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wd_clk_i,
  input  logic             run_i,
  input  logic             clk_sel_i,
  input  logic [PRE_W-1:0] presc_i,
  input  logic             clr_i,
  output logic             step_o
);
  localparam int DIV_W = FIX_LOG2 + (2**PRE_W) - 1;
  localparam int SH_W  = $clog2(DIV_W + 1);

  logic [SYNC_STAGES:0] sync_q;
  logic [DIV_W-1:0]     div_q, mask;
  logic [SH_W-1:0]      shamt;
  logic                 wd_rise, tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], wd_clk_i};
  end

  always_comb begin
    wd_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
    tick    = run_i && (clk_sel_i ? wd_rise : 1'b1);
    shamt   = SH_W'(FIX_LOG2) + SH_W'(presc_i);
    // low FIX_LOG2+N bits; wraps to all ones at the top setting
    mask    = (DIV_W'(1) << shamt) - DIV_W'(1);
    step_o  = tick && ((div_q & mask) == mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   div_q <= '0;
    else if (clr_i) div_q <= '0;
    else if (tick)  div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt #(
  parameter int         CNT_W   = 8,
  parameter logic [7:0] CNT_RST = 8'hFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             underflow_o
);
  logic [CNT_W-1:0] cnt_q;

  assign underflow_o = step_i && !load_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= CNT_W'(CNT_RST);
    else if (load_i || underflow_o) cnt_q <= reload_i;
    else if (step_i)            cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int LW = $clog2(LEN + 1);
  logic [LW-1:0] left_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      left_q <= '0;
    end else if (trig_i) begin
      act_q  <= 1'b1;
      left_q <= LW'(LEN - 1);
    end else if (act_q) begin
      if (left_q == '0) act_q  <= 1'b0;
      else              left_q <= left_q - LW'(1);
    end
  end

  assign pulse_o = act_q;
endmodule

// File: rtl/wdt_feed_guard.sv
module wdt_feed_guard
  import wdt_pkg::*;
#(
  parameter int                FIX_DIV_LOG2 = 5,
  parameter int                RST_LEN      = 4,
  parameter int                SYNC_STAGES  = 2,
  parameter logic [DATA_W-1:0] RELOAD_RST   = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wd_clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rst_req_o,
  output logic              timeout_o
);
  ctrl_t             ctrl_act;
  logic [DATA_W-1:0] reload_val, cnt_val;
  logic              feed_ok, bad_feed, step, underflow;

  wdt_feed_ctrl #(.RELOAD_RST(RELOAD_RST)) u_feed (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .underflow_i(underflow),
    .ctrl_o(ctrl_act),
    .reload_o(reload_val),
    .feed_ok_o(feed_ok),
    .bad_feed_o(bad_feed)
  );

  wdt_tick_gen #(
    .FIX_LOG2(FIX_DIV_LOG2), .PRE_W(PRESC_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk_i, .rst_ni, .wd_clk_i,
    .run_i(ctrl_act.run),
    .clk_sel_i(ctrl_act.clk_sel),
    .presc_i(ctrl_act.presc),
    .clr_i(feed_ok),
    .step_o(step)
  );

  wdt_down_cnt #(.CNT_W(DATA_W), .CNT_RST(RELOAD_RST)) u_cnt (
    .clk_i, .rst_ni,
    .load_i(feed_ok),
    .reload_i(reload_val),
    .step_i(step),
    .cnt_o(cnt_val),
    .underflow_o(underflow)
  );

  wdt_rst_pulse #(.LEN(RST_LEN)) u_pulse (
    .clk_i, .rst_ni,
    .trig_i(bad_feed | underflow),
    .pulse_o(rst_req_o)
  );

  assign timeout_o = ctrl_act.tof;
endmodule

// File: rtl/wdt_feed_guard_chk.sv
module wdt_feed_guard_chk
  import wdt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input ctrl_t             ctrl_i,
  input logic              feed_ok_i,
  input logic              bad_feed_i,
  input logic              underflow_i,
  input logic [DATA_W-1:0] cnt_i,
  input logic [DATA_W-1:0] reload_i,
  input logic              rst_req_o,
  input logic              timeout_o
);
  AST_BAD_FEED_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_feed_i |=> rst_req_o);  // R2 R3
  AST_FEED_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bad_feed_i && feed_ok_i));  // R1
  AST_FEED_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feed_ok_i |=> (cnt_i == $past(reload_i)));  // R1
  AST_CTRL_STAGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !feed_ok_i |=> $stable({ctrl_i.run, ctrl_i.clk_sel, ctrl_i.presc}));  // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.run && !feed_ok_i) |=> $stable(cnt_i));  // R5
  AST_UFL_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_i |=> (timeout_o && rst_req_o));  // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !feed_ok_i) |=> timeout_o);  // R7
  AST_PULSE_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |=> rst_req_o);  // R8
endmodule

bind wdt_feed_guard wdt_feed_guard_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl_act),
  .feed_ok_i(feed_ok), .bad_feed_i(bad_feed), .underflow_i(underflow),
  .cnt_i(cnt_val), .reload_i(reload_val),
  .rst_req_o(rst_req_o), .timeout_o(timeout_o)
);

// File: tb/wdt_feed_guard_test.sv
module wdt_feed_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {addr1, data1, addr2, data2, expect_reset}
  localparam logic [20:0] VEC [NVEC] = '{
    {2'd2, 8'hA5, 2'd3, 8'h5A, 1'b0},
    {2'd2, 8'hA5, 2'd3, 8'h5B, 1'b1},
    {2'd3, 8'h5A, 2'd3, 8'h5A, 1'b1},
    {2'd2, 8'h5A, 2'd3, 8'hA5, 1'b1},
    {2'd2, 8'hA5, 2'd1, 8'h10, 1'b1},
    {2'd1, 8'h10, 2'd1, 8'h20, 1'b0},
    {2'd2, 8'hA5, 2'd2, 8'hA5, 1'b1},
    {2'd0, 8'h00, 2'd1, 8'h33, 1'b1},
    {2'd2, 8'hA4, 2'd1, 8'hFF, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, wd_clk = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic rst_req, timeout;
  int n_cmp = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(CLK_PERIOD*4) wd_clk = ~wd_clk;

  wdt_feed_guard uut (
    .clk_i(clk), .rst_ni(rst_n), .wd_clk_i(wd_clk), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rst_req_o(rst_req), .timeout_o(timeout)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_cmp++; n_err++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    check("R9 reset rst_req", rst_req, 0);
    check("R9 reset timeout", timeout, 0);

    // table of two-write sequences, run disabled
    for (int i = 0; i < NVEC; i++) begin
      logic [20:0] v;
      v = VEC[i];
      wr(v[20:19], v[18:11]);
      wr(v[10:9], v[8:1]);
      check($sformatf("R1/R2/R3/R4 vector %0d", i), rst_req, v[0]);
      idle(6);
      check($sformatf("R8 vector %0d pulse over", i), rst_req, 0);
    end

    // staged control never committed: timer stays idle
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h00);
    check("R4 uncommitted ctrl reset", rst_req, 1);
    idle(100);
    check("R4 staged run ignored timeout", timeout, 0);
    check("R4 staged run ignored rst", rst_req, 0);

    // N=1, R=2, system clock: underflow 64*3 cycles after commit
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h09);
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h5A);
    check("R4 commit no reset", rst_req, 0);
    idle(191);
    check("R6 before underflow rst", rst_req, 0);
    check("R6 before underflow flag", timeout, 0);
    idle(1);
    check("R5/R6 underflow rst", rst_req, 1);
    check("R6 underflow flag", timeout, 1);
    idle(3);
    check("R8 pulse last cycle", rst_req, 1);
    idle(1);
    check("R8 pulse ended", rst_req, 0);

    // plain feed keeps the flag
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h5A);
    check("R7 flag sticky over feed", timeout, 1);
    // commit 0 clears flag and stops counting
    wr(2'd0, 8'h00);
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h5A);
    check("R7 flag cleared", timeout, 0);
    idle(500);
    check("R5 run off no timeout", rst_req | timeout, 0);
    // committing a 1 does not set the flag
    wr(2'd0, 8'h02);
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h5A);
    check("R7 flag not settable", timeout, 0);

    // pulse retrigger
    wr(2'd3, 8'h5A);
    wr(2'd3, 8'h5A);
    idle(3);
    check("R8 retrigger extends", rst_req, 1);
    idle(1);
    check("R8 retrigger end", rst_req, 0);

    // watchdog clock source, N=0, R=0: 32 slow edges of period 8
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h05);
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h5A);
    begin
      int wait_n;
      wait_n = 0;
      while (!rst_req && wait_n < 400) begin
        @(negedge clk);
        wait_n++;
      end
      check("R5 slow clock timeout window", (wait_n >= 240 && wait_n <= 272), 1);
    end
    check("R6 slow clock flag", timeout, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule